// File: doc/BRIEF.md
# Windowed Deadman Timer with Two-Step Keyed Service

This block watches that software keeps running. Once enabled, a free-running counter advances by one on every system clock. If it reaches a programmed period, the block raises an event, pulses its timeout output and sets a sticky reset-cause bit. Software prevents the timeout by servicing the timer. It first writes an arming key to one register. It then writes a second key to another register, and that second write must fall inside a window that opens near the end of the period. Any key that is wrong, out of order or early is flagged as an error and raises the timeout output at once.

Every register is on a simple single-cycle bus: address, write data, write strobe and combinational read data. The control register also has set-only and clear-only aliases. In the cycle right after the enable bit drops, the block ignores all accesses. The reset-cause bit is not affected by the block's synchronous reset, so it can report a timeout across the reset that follows. Software clears it with a write to its clear alias.

Top module: `deadman_wdt`

## Requirements
- R1: After a synchronous reset, the registers hold these values: control (0x00) 0, count (0x40) 0, status (0x30) 0, period (0x60) PER_RST and window (0x70) WIN_RST.
- R2: Bit 15 of control is the enable. A plain write to 0x00 loads bit 15. A write to 0x08 sets only the bits written as 1, and a write to 0x04 clears only the bits written as 1.
- R3: While disabled, the count stays at 0, and writes to the service registers change no status bit.
- R4: While enabled, the count rises by one per clock and reads back at 0x40.
- R5: Status bit 0 (window open) is 1 exactly when count + window >= period.
- R6: A service that writes 0x40 in bits 15:8 at 0x10, then 0x08 in bits 7:0 at 0x20 while the window is open, returns the count to 0. No error is raised.
- R7: Status bit 7 (first-step error) sets when 0x10 is written with a wrong key, or when 0x20 is written without a prior valid arming write. It is sticky until reset.
- R8: Status bit 6 (second-step error) sets when an armed write to 0x20 carries a wrong key, or when it arrives while the window is closed.
- R9: When the count reaches the period, the next edge returns the count to 0, sets status bit 5 and drives timeout_evt high for one cycle.
- R10: Each step error drives timeout_evt high in the cycle after the faulty write.
- R11: A timeout sets bit 5 of the reset-cause register at 0x80. The bit survives the synchronous reset and is cleared by writing a 1 to bit 5 at 0x84.
- R12: In the cycle after the enable falls, writes are ignored and read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| timeout_evt | output | 1 | One-cycle pulse on a timeout or a step error |
| rst_cause | output | 1 | Sticky reset-cause bit |

## Verification
Each state flaw shows up at the ports within a few cycles. A stuck or skipped count is visible in the count readback on the very next clock. A wrong arming state turns a correct service into a first-step error, which sets status bit 7 and pulses timeout_evt one cycle after the clear write. A window comparison that is off by one shows in status bit 0 at the boundary count. A missing timeout leaves timeout_evt low one cycle after the count read shows the period.

// File: rtl/deadman_wdt.sv
module deadman_wdt #(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int CW      = 32,
  parameter int PER_RST = 64,
  parameter int WIN_RST = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic [DW-1:0] bus_rdata,
  output logic          timeout_evt,
  output logic          rst_cause
);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00), A_CCLR = AW'(8'h04), A_CSET = AW'(8'h08);
  localparam logic [AW-1:0] A_ARM = AW'(8'h10), A_KICK = AW'(8'h20), A_STAT = AW'(8'h30);
  localparam logic [AW-1:0] A_CNT = AW'(8'h40), A_PER = AW'(8'h60), A_WIN = AW'(8'h70);
  localparam logic [AW-1:0] A_RC = AW'(8'h80), A_RCCLR = AW'(8'h84);
  localparam logic [7:0] KEY_ARM = 8'h40, KEY_KICK = 8'h08;
  localparam int EN_BIT = 15, RC_BIT = 5;

  logic en_q, quiet_q, armed_q, evt_q, e1_q, e2_q, pulse_q;
  logic rc_q = 1'b0;
  logic [CW-1:0] cnt_q, per_q, win_q;
  logic en_n, wr_ok, win_open, arm_wr, kick_wr, arm_good, kick_good, hit;

  assign wr_ok    = bus_we & ~quiet_q;
  assign arm_wr   = wr_ok & en_q & (bus_addr == A_ARM);
  assign kick_wr  = wr_ok & en_q & (bus_addr == A_KICK);
  assign win_open = ({1'b0, cnt_q} + {1'b0, win_q}) >= {1'b0, per_q};
  assign arm_good = bus_wdata[15:8] == KEY_ARM;
  assign kick_good = kick_wr & armed_q & (bus_wdata[7:0] == KEY_KICK) & win_open;
  assign hit      = en_q & ~kick_good & (cnt_q >= per_q);

  always_comb begin
    en_n = en_q;
    if (wr_ok) begin
      if (bus_addr == A_CTRL) en_n = bus_wdata[EN_BIT];
      else if (bus_addr == A_CCLR && bus_wdata[EN_BIT]) en_n = 1'b0;
      else if (bus_addr == A_CSET && bus_wdata[EN_BIT]) en_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; quiet_q <= 1'b0; armed_q <= 1'b0; pulse_q <= 1'b0;
      evt_q <= 1'b0; e1_q <= 1'b0; e2_q <= 1'b0;
      cnt_q <= '0; per_q <= CW'(PER_RST); win_q <= CW'(WIN_RST);
    end else begin
      en_q    <= en_n;
      quiet_q <= en_q & ~en_n;
      pulse_q <= 1'b0;
      if (wr_ok && bus_addr == A_PER) per_q <= CW'(bus_wdata);
      if (wr_ok && bus_addr == A_WIN) win_q <= CW'(bus_wdata);
      if (!en_q) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (arm_wr) begin
          if (arm_good) armed_q <= 1'b1;
          else begin e1_q <= 1'b1; pulse_q <= 1'b1; end
        end
        if (kick_wr) begin
          armed_q <= 1'b0;
          if (!armed_q) begin e1_q <= 1'b1; pulse_q <= 1'b1; end
          else if (!kick_good) begin e2_q <= 1'b1; pulse_q <= 1'b1; end
          else cnt_q <= '0;
        end
        if (hit) begin
          cnt_q <= '0; armed_q <= 1'b0; evt_q <= 1'b1; pulse_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hit && !rst) rc_q <= 1'b1;
    else if (wr_ok && bus_addr == A_RCCLR && bus_wdata[RC_BIT]) rc_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (!quiet_q) begin
      case (bus_addr)
        A_CTRL:  bus_rdata[EN_BIT] = en_q;
        A_STAT:  bus_rdata[7:0] = {e1_q, e2_q, evt_q, 4'b0, win_open};
        A_CNT:   bus_rdata = DW'(cnt_q);
        A_PER:   bus_rdata = DW'(per_q);
        A_WIN:   bus_rdata = DW'(win_q);
        A_RC:    bus_rdata[RC_BIT] = rc_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign timeout_evt = pulse_q;
  assign rst_cause   = rc_q;
endmodule

// File: rtl/deadman_wdt_chk.sv
module deadman_wdt_chk #(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_we,
  input logic [DW-1:0] bus_rdata,
  input logic          timeout_evt,
  input logic          en_q,
  input logic          quiet_q,
  input logic          evt_q,
  input logic          e1_q,
  input logic          e2_q,
  input logic          rc_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] per_q,
  input logic [CW-1:0] win_q
);
  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> cnt_q == '0);
  assert_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (en_q && !bus_we && cnt_q < per_q) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |-> (evt_q || e1_q || e2_q));
  assert_first_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    e1_q |=> e1_q);
  assert_cause_rise_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(rc_q) |-> timeout_evt);
  assert_quiet_hold_R12: assert property (@(posedge clk) disable iff (rst)
    quiet_q |=> ($stable(per_q) && $stable(win_q)));
  assert_quiet_read_R12: assert property (@(posedge clk) disable iff (rst)
    quiet_q |-> bus_rdata == '0);
endmodule

bind deadman_wdt deadman_wdt_chk #(.DW(DW), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_rdata(bus_rdata),
  .timeout_evt(timeout_evt), .en_q(en_q), .quiet_q(quiet_q), .evt_q(evt_q),
  .e1_q(e1_q), .e2_q(e2_q), .rc_q(rc_q), .cnt_q(cnt_q), .per_q(per_q),
  .win_q(win_q)
);

// File: tb/deadman_wdt_tb_top.sv
module deadman_wdt_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        timeout_evt, rst_cause;
  int errors = 0, checks = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  deadman_wdt dut_i (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .timeout_evt(timeout_evt), .rst_cause(rst_cause));

  // {write addr, write data, read addr, expected read}
  localparam logic [79:0] VEC [5] = '{
    {8'h60, 32'h0000_1234, 8'h60, 32'h0000_1234},
    {8'h70, 32'h0000_0055, 8'h70, 32'h0000_0055},
    {8'h08, 32'h0000_8000, 8'h00, 32'h0000_8000},
    {8'h30, 32'hFFFF_FFFF, 8'h30, 32'h0000_0000},
    {8'h04, 32'h0000_8000, 8'h00, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic setup();
    do_reset();
    wr(8'h60, 32'd20);
    wr(8'h70, 32'd5);
    wr(8'h08, 32'h8000);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h40, v); chk("R1 count", v, 32'h0);
    rd(8'h30, v); chk("R1 status", v, 32'h0);
    rd(8'h60, v); chk("R1 period", v, 32'd64);
    rd(8'h70, v); chk("R1 window", v, 32'd16);
    chk("R11 cause at start", {31'b0, rst_cause}, 32'h0);

    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      wr(VEC[i][79:72], VEC[i][71:40]);
      rd(VEC[i][39:32], v);
      chk("R2 table", v, VEC[i][31:0]);
    end

    do_reset();
    idle(8);
    wr(8'h10, 32'h1100);
    wr(8'h20, 32'h08);
    rd(8'h40, v); chk("R3 count held", v, 32'h0);
    rd(8'h30, v); chk("R3 status untouched", v, 32'h0);

    setup();
    idle(7);
    rd(8'h40, v); chk("R4 count", v, 32'd7);
    rd(8'h30, v); chk("R5 window closed", v, 32'h0);
    idle(8);
    rd(8'h40, v); chk("R4 count later", v, 32'd15);
    rd(8'h30, v); chk("R5 window open", v, 32'h1);
    wr(8'h10, 32'h4000);
    wr(8'h20, 32'h08);
    rd(8'h40, v); chk("R6 cleared count", v, 32'h0);
    rd(8'h30, v); chk("R6 no error", v, 32'h0);
    chk("R6 no pulse", {31'b0, timeout_evt}, 32'h0);

    setup();
    idle(5);
    wr(8'h10, 32'h4000);
    wr(8'h20, 32'h08);
    chk("R10 pulse on early kick", {31'b0, timeout_evt}, 32'h1);
    rd(8'h30, v); chk("R8 early kick", v, 32'h40);

    setup();
    wr(8'h20, 32'h08);
    rd(8'h30, v); chk("R7 kick unarmed", v, 32'h80);

    setup();
    wr(8'h10, 32'h4100);
    chk("R10 pulse on bad arm", {31'b0, timeout_evt}, 32'h1);
    rd(8'h30, v); chk("R7 bad arm key", v, 32'h80);

    setup();
    idle(15);
    wr(8'h10, 32'h4000);
    wr(8'h20, 32'h09);
    rd(8'h30, v); chk("R8 bad kick key", v, 32'h41);

    setup();
    idle(20);
    rd(8'h40, v); chk("R9 count at period", v, 32'd20);
    chk("R9 no pulse yet", {31'b0, timeout_evt}, 32'h0);
    idle(1);
    chk("R9 pulse", {31'b0, timeout_evt}, 32'h1);
    rd(8'h40, v); chk("R9 count wrapped", v, 32'h0);
    rd(8'h30, v); chk("R9 event bit", v, 32'h20);
    rd(8'h80, v); chk("R11 cause set", v, 32'h20);
    idle(1);
    chk("R9 pulse one cycle", {31'b0, timeout_evt}, 32'h0);
    do_reset();
    rd(8'h80, v); chk("R11 cause survives reset", v, 32'h20);
    wr(8'h84, 32'h20);
    rd(8'h80, v); chk("R11 cause cleared", v, 32'h0);

    setup();
    idle(3);
    wr(8'h04, 32'h8000);
    rd(8'h60, v); chk("R12 quiet read", v, 32'h0);
    wr(8'h60, 32'h33);
    rd(8'h60, v); chk("R12 write ignored", v, 32'd20);
    rd(8'h00, v); chk("R2 clear alias", v, 32'h0);
    idle(2);
    rd(8'h40, v); chk("R3 count after disable", v, 32'h0);

    finish_run();
  end
endmodule